// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Model

This block is a clocked behavioural stand-in for a 16-bit asynchronous static RAM with two byte lanes. It decodes five active-low controls (chip select, write enable, output enable, upper-lane enable and lower-lane enable) into standby, per-lane read, per-lane write or outputs-off. A bidirectional data bus does not fit a tri-state-free flow, so the model splits it into a data-in port, a data-out port and one drive-enable bit per lane.

All pins are sampled on the rising clock edge. The outputs follow the controls sampled at the most recent edge. A write stays pending while the write overlap lasts. The enabled lanes are written to the array at the first sample in which that lane's overlap has ended. The array depth is a parameter kept small by default. Address bits above the array index are ignored, so the upper address space aliases onto the array.

Top module: `sram_lane_model`

## Requirements
- R1: The word index is the address modulo DEPTH (default 1024). Address bits at and above log2(DEPTH) are ignored, so addresses that differ only there reach the same word.
- R2: While chip select is high, both drive enables are 0 and no write is recorded, whatever the other controls are.
- R3: With chip select low, write enable high and output enable low, drive enable bit 0 (data bits 7:0) is 1 exactly when the lower enable is low. Drive enable bit 1 (data bits 15:8) is 1 exactly when the upper enable is low. A driven lane shows the stored byte at the sampled address.
- R4: While chip select and write enable are both low, both drive enables are 0, even when output enable is low.
- R5: A lane's write overlap is chip select, write enable and that lane's enable all low in the same sample. When a lane's overlap ends, that lane stores the data-in byte and address from the last overlapping sample, at the first sample without the overlap. A read in that same sample already returns the new byte.
- R6: With chip select low and write enable high, both drive enables are 0 if output enable is high or both lane enables are high.
- R7: With both lane enables low, a write or read covers the full word. A write with one lane enable low leaves the other lane's stored byte unchanged.
- R8: A lane whose drive enable is 0 shows 0 on its data-out bits.
- R9: Drive enables and data-out reflect the pins sampled at the most recent rising clock edge.
- R10: While reset is low, both drive enables are 0. A reset drops any write that is pending and not yet committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (18) | Word address |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper lane (bits 15:8) enable, active low |
| lb_n | input | 1 | Lower lane (bits 7:0) enable, active low |
| din | input | DATA_W (16) | Write data |
| dout | output | DATA_W (16) | Read data, 0 on lanes not driven |
| drv_en | output | 2 | Per-lane drive enable, bit 0 lower, bit 1 upper |

## Verification
Every result appears one edge after the pins that cause it. Drive enables and read data follow the pins sampled at that edge. A write commits at the edge that first sees its overlap gone, so a read sampled at that same edge already returns the new data. The bench drives pins at the falling edge and updates its reference model at the rising edge, in the same order the design uses. It then compares outputs one time unit after that edge, which leaves exactly one edge between stimulus and check.

// File: rtl/sram_lane_model.sv
module sram_lane_model #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [1:0]        drv_en
);
  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;
  localparam int IDX_W  = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];

  logic             cs_q, we_q, oe_q;
  logic [LANES-1:0] be_q;
  logic [IDX_W-1:0] idx_q;
  logic [LANES-1:0] pend_q;
  logic [IDX_W-1:0] pend_idx;
  logic [DATA_W-1:0] pend_data;

  logic [IDX_W-1:0] idx;
  logic [LANES-1:0] ov;
  logic             rd_ok;
  logic             unused_hi;

  assign idx       = addr[IDX_W-1:0];
  assign unused_hi = ^addr[ADDR_W-1:IDX_W];
  assign ov        = {LANES{~cs_n & ~we_n}} & ~{ub_n, lb_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q      <= 1'b1;
      we_q      <= 1'b1;
      oe_q      <= 1'b1;
      be_q      <= '1;
      idx_q     <= '0;
      pend_q    <= '0;
      pend_idx  <= '0;
      pend_data <= '0;
    end else begin
      cs_q   <= cs_n;
      we_q   <= we_n;
      oe_q   <= oe_n;
      be_q   <= {ub_n, lb_n};
      idx_q  <= idx;
      pend_q <= ov;
      if (|ov) pend_idx <= idx;
      for (int l = 0; l < LANES; l++)
        if (ov[l]) pend_data[l*LANE_W +: LANE_W] <= din[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++)
      if (pend_q[l] && !ov[l])
        mem[pend_idx][l*LANE_W +: LANE_W] <= pend_data[l*LANE_W +: LANE_W];
  end

  assign rd_ok  = ~cs_q & we_q & ~oe_q;
  assign drv_en = {LANES{rd_ok}} & ~be_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[g*LANE_W +: LANE_W] = drv_en[g] ? mem[idx_q][g*LANE_W +: LANE_W] : '0;
  end

  p_desel_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> drv_en == 2'b00);

  p_write_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |=> drv_en == 2'b00);

  p_read_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && we_n && !oe_n) |=> drv_en == ~$past({ub_n, lb_n}));

  p_oe_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && we_n && (oe_n || (ub_n && lb_n))) |=> drv_en == 2'b00);

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en[0] |-> dout[LANE_W-1:0] == '0);

  p_idle_zero_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en[1] |-> dout[DATA_W-1:LANE_W] == '0);

  always_comb
    if (!rst_n) p_reset_hiz_r10: assert (drv_en == 2'b00);
endmodule

// File: tb/sram_lane_model_tb_top.sv
module sram_lane_model_tb_top;
  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] addr = '0;
  logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [1:0]  drv_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] mlane [2][int];
  bit         pnd [2];
  int         pidx;
  logic [7:0] pdat [2];

  always #5 clk = ~clk;

  sram_lane_model dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .we_n(we_n),
    .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n), .din(din), .dout(dout), .drv_en(drv_en)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit [1:0] ov;
    int ix;
    ix = int'(addr) % DEPTH;
    for (int l = 0; l < 2; l++) begin
      ov[l] = !cs_n && !we_n && !(l == 0 ? lb_n : ub_n);
      if (pnd[l] && !ov[l]) begin
        mlane[l][pidx] = pdat[l];
        pnd[l] = 0;
      end
    end
    for (int l = 0; l < 2; l++)
      if (ov[l]) begin
        pnd[l] = 1;
        pdat[l] = din[l*8 +: 8];
      end
    if (ov != 2'b00) pidx = ix;
  endtask

  task automatic compare(string tag);
    logic [1:0] ed;
    logic [15:0] ex;
    int ix;
    ix = int'(addr) % DEPTH;
    ed = (!cs_n && we_n && !oe_n) ? ~{ub_n, lb_n} : 2'b00;
    chk({tag, " drv"}, {14'd0, drv_en}, {14'd0, ed});
    for (int l = 0; l < 2; l++) begin
      if (!ed[l]) chk({tag, " idle"}, {8'd0, dout[l*8 +: 8]}, 16'd0);
      else if (mlane[l].exists(ix)) chk({tag, " data"}, {8'd0, dout[l*8 +: 8]}, {8'd0, mlane[l][ix]});
    end
  endtask

  task automatic step(string tag, logic c, logic w, logic o, logic u, logic lo,
                      logic [17:0] a, logic [15:0] d);
    @(negedge clk);
    cs_n = c; we_n = w; oe_n = o; ub_n = u; lb_n = lo; addr = a; din = d;
    @(posedge clk);
    model_edge();
    #1;
    compare(tag);
  endtask

  task automatic wr(string tag, logic u, logic lo, logic [17:0] a, logic [15:0] d);
    step(tag, 0, 0, 1, u, lo, a, d);
    step(tag, 0, 1, 1, 1, 1, a, d);
  endtask

  task automatic rd(string tag, logic u, logic lo, logic [17:0] a);
    step(tag, 0, 1, 0, u, lo, a, 16'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R10: reset holds outputs off even with a read requested
    cs_n = 0; we_n = 1; oe_n = 0; ub_n = 0; lb_n = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset drv", {14'd0, drv_en}, 16'd0);
    chk("R10 reset dout", dout, 16'd0);
    @(negedge clk);
    rst_n = 1;
    step("R2 idle", 1, 1, 1, 1, 1, 0, 0);

    // R7 word writes and reads
    wr("R7 word wr", 0, 0, 18'd5, 16'hA1B2);
    wr("R7 word wr", 0, 0, 18'd6, 16'hC3D4);
    rd("R7 word rd", 0, 0, 18'd5);
    rd("R7 word rd", 0, 0, 18'd6);
    // R3 single-lane reads
    rd("R3 low lane", 1, 0, 18'd5);
    rd("R3 high lane", 0, 1, 18'd5);
    // R7 single-lane write keeps other lane
    wr("R7 hi only", 0, 1, 18'd5, 16'h7711);
    rd("R7 after hi", 0, 0, 18'd5);
    wr("R7 lo only", 1, 0, 18'd6, 16'h2299);
    rd("R7 after lo", 0, 0, 18'd6);
    // R4 write with output enable low
    step("R4 wr oe low", 0, 0, 0, 0, 0, 18'd7, 16'h5A5A);
    step("R4 wr oe low", 0, 0, 0, 0, 0, 18'd7, 16'h5A5A);
    rd("R4 readback", 0, 0, 18'd7);
    // R2 deselected write attempt does not store
    step("R2 desel", 1, 0, 0, 0, 0, 18'd7, 16'hFFFF);
    step("R2 desel", 1, 1, 0, 0, 0, 18'd7, 16'hFFFF);
    rd("R2 readback", 0, 0, 18'd7);
    // R6 outputs off
    step("R6 oe high", 0, 1, 1, 0, 0, 18'd7, 0);
    step("R6 no lanes", 0, 1, 0, 1, 1, 18'd7, 0);
    // R1 aliasing of upper address bits
    wr("R1 alias wr", 0, 0, 18'd3 + 18'(DEPTH * 37), 16'h1357);
    rd("R1 alias rd", 0, 0, 18'd3);
    rd("R1 alias rd2", 0, 0, 18'd3 + 18'(DEPTH * 100));
    // R5 long overlap, last data wins, read in the commit sample
    step("R5 ovl", 0, 0, 0, 0, 0, 18'd9, 16'h1111);
    step("R5 ovl", 0, 0, 0, 0, 0, 18'd9, 16'h2222);
    step("R5 ovl", 0, 0, 0, 0, 0, 18'd9, 16'h3333);
    rd("R5 commit rd", 0, 0, 18'd9);
    // R5 lanes end at different samples
    step("R5 split", 0, 0, 1, 0, 0, 18'd10, 16'hAABB);
    step("R5 split", 0, 0, 1, 0, 1, 18'd10, 16'hCCDD);
    rd("R5 split rd", 0, 0, 18'd10);
    // R10 reset drops a pending write
    step("R10 pend", 0, 0, 1, 0, 0, 18'd9, 16'hDEAD);
    @(negedge clk);
    rst_n = 0;
    pnd[0] = 0; pnd[1] = 0;
    #1;
    chk("R10 mid reset drv", {14'd0, drv_en}, 16'd0);
    @(negedge clk);
    cs_n = 0; we_n = 1; oe_n = 0; ub_n = 0; lb_n = 0;
    rst_n = 1;
    rd("R10 dropped", 0, 0, 18'd9);
    // R8 R9 R3 mixed traffic over a small address set
    for (int i = 0; i < 400; i++) begin
      logic [17:0] a;
      a = 18'($urandom_range(0, 7)) + 18'(DEPTH * $urandom_range(0, 3));
      step("R8 R9 mix", logic'($urandom_range(0, 4) == 0), logic'($urandom_range(0, 1)),
           logic'($urandom_range(0, 2) == 0), logic'($urandom_range(0, 1)),
           logic'($urandom_range(0, 1)), a, 16'($urandom));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule